// File: doc/BRIEF.md
# Interlace-Aware Capture Clipping Window

This block takes a camera pixel stream and passes on only the pixels that fall inside a programmed rectangle. The stream arrives as pixel data with a pixel-valid qualifier, a one-cycle line marker (`hSync`) and a one-cycle frame or field marker (`vSync`), plus a field-identity input. Two counters track where each pixel sits. The horizontal counter counts valid pixels since the last line marker. The vertical counter counts lines since the last frame marker. A pixel is forwarded when both counts are inside the window. The block also flags the first and last forwarded pixel of each line.

The rectangle is set by a horizontal start, a horizontal size, a vertical size and two vertical start lines. With an interlaced sensor, the field identity seen at `vSync` picks the even-field or odd-field start line. With a progressive sensor, the odd-field start is ignored. All window settings are captured at `vSync`, so a frame is always clipped with one consistent set of values. A horizontal size that is not a multiple of 16 raises an error flag, and that frame produces no output.

Top module: `capture_window`

## Requirements
- R1: While `rstN` is low, `outValid`, `outLineStart`, `outLineEnd` and `cfgError` are all 0.
- R2: After a line marker, the first valid pixel has horizontal index 0. A pixel is forwarded only if its index h satisfies hStart <= h < hStart + hSize.
- R3: After a frame marker, the line opened by the first following `hSync` is line 0. Only lines v with vStart <= v < vStart + vSize are forwarded.
- R4: With `interlaced` = 1, the level of `fieldOdd` on the `vSync` cycle selects the start line: 1 selects `cfgVStartOdd` and 0 selects `cfgVStartEven`.
- R5: With `interlaced` = 0, `cfgVStartEven` applies to every frame, and `cfgVStartOdd` and `fieldOdd` have no effect.
- R6: If `cfgHSize[3:0]` is nonzero at `vSync`, then `cfgError` is 1 from the cycle after that `vSync` until the next `vSync`, and `outValid` stays 0 for that frame.
- R7: Window inputs are sampled only on a `vSync` cycle. Changes made in the middle of a frame first affect the next frame.
- R8: `outLineStart` marks the forwarded pixel with index hStart. `outLineEnd` marks the forwarded pixel with index hStart + hSize - 1.
- R9: Outputs are registered one cycle after the input pixel, and `pixOut` equals that pixel's data. Cycles with `pixValid` = 0 do not advance the horizontal count.
- R10: A cycle with `hSync` or `vSync` high carries no pixel, even if `pixValid` is high. No pixel is forwarded before the first `vSync` after reset, or before the first `hSync` of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Pixel qualifier |
| hSync | input | 1 | One-cycle line marker |
| vSync | input | 1 | One-cycle frame/field marker |
| fieldOdd | input | 1 | Field identity, sampled at vSync (1 = odd) |
| pixIn | input | DW | Pixel data |
| interlaced | input | 1 | 1 = interlaced sensor, 0 = progressive |
| cfgHStart | input | CW | First forwarded pixel index |
| cfgHSize | input | CW | Forwarded pixels per line, multiple of 16 |
| cfgVStartEven | input | CW | First forwarded line, even field or progressive |
| cfgVStartOdd | input | CW | First forwarded line, odd field |
| cfgVSize | input | CW | Forwarded lines per frame/field |
| outValid | output | 1 | Forwarded pixel qualifier |
| pixOut | output | DW | Forwarded pixel data |
| outLineStart | output | 1 | First forwarded pixel of a line |
| outLineEnd | output | 1 | Last forwarded pixel of a line |
| cfgError | output | 1 | Horizontal size not a multiple of 16 |

## Verification
All four pixel outputs respond to the input cycle that a given clock edge captures. They are due one edge later, and `cfgError` changes at the edge that captures `vSync`. On each falling edge the driver applies one input cycle and queues the outputs it predicts for that cycle. The monitor waits 2 ns after the next rising edge and compares one queued item, so every comparison lands exactly one register stage after its stimulus. The prediction comes from a window model that tracks counters and settings captured at `vSync`.

// File: rtl/capture_window_pkg.sv
package capture_window_pkg;

  typedef struct packed {
    logic latchCfg;  // frame/field boundary: capture window settings
    logic useOdd;    // odd-field vertical start applies
    logic pixel;     // this cycle carries a countable pixel
  } ctrlStrobe_t;

endpackage

// File: rtl/capture_window_ctrl.sv
module capture_window_ctrl
  import capture_window_pkg::*;
#(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic          hSync,
  input  logic          vSync,
  input  logic          fieldOdd,
  input  logic          interlaced,
  output ctrlStrobe_t   strb,
  output logic [CW-1:0] hCnt,
  output logic [CW-1:0] lineCnt,
  output logic          lineOk,
  output logic          frameOk
);

  localparam logic [CW-1:0] CntMax = {CW{1'b1}};

  always_comb begin
    strb.latchCfg = vSync;
    strb.useOdd   = interlaced & fieldOdd;
    strb.pixel    = pixValid & ~hSync & ~vSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt    <= '0;
      lineCnt <= '0;
      lineOk  <= 1'b0;
      frameOk <= 1'b0;
    end else if (vSync) begin
      hCnt    <= '0;
      lineCnt <= '0;
      lineOk  <= 1'b0;
      frameOk <= 1'b1;
    end else if (hSync) begin
      hCnt   <= '0;
      lineOk <= 1'b1;
      if (lineOk && lineCnt != CntMax) lineCnt <= lineCnt + 1'b1;
    end else if (pixValid && hCnt != CntMax) begin
      hCnt <= hCnt + 1'b1;
    end
  end

endmodule

// File: rtl/capture_window_dp.sv
module capture_window_dp
  import capture_window_pkg::*;
#(
  parameter int CW = 15,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strb,
  input  logic [CW-1:0] hCnt,
  input  logic [CW-1:0] lineCnt,
  input  logic          lineOk,
  input  logic          frameOk,
  input  logic [DW-1:0] pixIn,
  input  logic [CW-1:0] cfgHStart,
  input  logic [CW-1:0] cfgHSize,
  input  logic [CW-1:0] cfgVStartEven,
  input  logic [CW-1:0] cfgVStartOdd,
  input  logic [CW-1:0] cfgVSize,
  output logic          outValid,
  output logic [DW-1:0] pixOut,
  output logic          outLineStart,
  output logic          outLineEnd,
  output logic          cfgError
);

  localparam int EW = CW + 1;
  localparam int AlignBits = 4;

  logic [EW-1:0] hStartS, hEndS, vStartS, vEndS;
  logic [CW-1:0] vStartSel;
  logic          inH, inV, take;

  assign vStartSel = strb.useOdd ? cfgVStartOdd : cfgVStartEven;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hStartS  <= '0;
      hEndS    <= '0;
      vStartS  <= '0;
      vEndS    <= '0;
      cfgError <= 1'b0;
    end else if (strb.latchCfg) begin
      hStartS  <= {1'b0, cfgHStart};
      hEndS    <= {1'b0, cfgHStart} + {1'b0, cfgHSize};
      vStartS  <= {1'b0, vStartSel};
      vEndS    <= {1'b0, vStartSel} + {1'b0, cfgVSize};
      cfgError <= |cfgHSize[AlignBits-1:0];
    end
  end

  always_comb begin
    inH  = ({1'b0, hCnt} >= hStartS) && ({1'b0, hCnt} < hEndS);
    inV  = ({1'b0, lineCnt} >= vStartS) && ({1'b0, lineCnt} < vEndS);
    take = strb.pixel && frameOk && lineOk && !cfgError && inH && inV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outLineStart <= 1'b0;
      outLineEnd   <= 1'b0;
      pixOut       <= '0;
    end else begin
      outValid     <= take;
      outLineStart <= take && ({1'b0, hCnt} == hStartS);
      outLineEnd   <= take && ({1'b0, hCnt} + 1'b1 == hEndS);
      pixOut       <= pixIn;
    end
  end

endmodule

// File: rtl/capture_window.sv
module capture_window
  import capture_window_pkg::*;
#(
  parameter int CW = 15,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic          hSync,
  input  logic          vSync,
  input  logic          fieldOdd,
  input  logic [DW-1:0] pixIn,
  input  logic          interlaced,
  input  logic [CW-1:0] cfgHStart,
  input  logic [CW-1:0] cfgHSize,
  input  logic [CW-1:0] cfgVStartEven,
  input  logic [CW-1:0] cfgVStartOdd,
  input  logic [CW-1:0] cfgVSize,
  output logic          outValid,
  output logic [DW-1:0] pixOut,
  output logic          outLineStart,
  output logic          outLineEnd,
  output logic          cfgError
);

  ctrlStrobe_t   strb;
  logic [CW-1:0] hCnt, lineCnt;
  logic          lineOk, frameOk;

  capture_window_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .hSync(hSync), .vSync(vSync),
    .fieldOdd(fieldOdd), .interlaced(interlaced), .strb(strb), .hCnt(hCnt),
    .lineCnt(lineCnt), .lineOk(lineOk), .frameOk(frameOk)
  );

  capture_window_dp #(.CW(CW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hCnt(hCnt), .lineCnt(lineCnt),
    .lineOk(lineOk), .frameOk(frameOk), .pixIn(pixIn), .cfgHStart(cfgHStart),
    .cfgHSize(cfgHSize), .cfgVStartEven(cfgVStartEven), .cfgVStartOdd(cfgVStartOdd),
    .cfgVSize(cfgVSize), .outValid(outValid), .pixOut(pixOut),
    .outLineStart(outLineStart), .outLineEnd(outLineEnd), .cfgError(cfgError)
  );

endmodule

// File: rtl/capture_window_checker.sv
module capture_window_checker #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          pixValid,
  input logic          hSync,
  input logic          vSync,
  input logic [DW-1:0] pixIn,
  input logic          outValid,
  input logic [DW-1:0] pixOut,
  input logic          outLineStart,
  input logic          outLineEnd,
  input logic          cfgError
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> !(outValid || outLineStart || outLineEnd || cfgError));

  a_r9_valid_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(pixValid));

  a_r9_data_passes: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> pixOut == $past(pixIn));

  a_r10_sync_no_pixel: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hSync) || $past(vSync)) |-> !outValid);

  a_r6_error_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !outValid);

  a_r7_err_at_vsync: assert property (@(posedge clk) disable iff (!rstN)
    !$past(vSync) |-> $stable(cfgError));

  a_r8_markers_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outLineStart || outLineEnd) |-> outValid);

endmodule

bind capture_window capture_window_checker #(.DW(DW)) u_checker (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .hSync(hSync), .vSync(vSync),
  .pixIn(pixIn), .outValid(outValid), .pixOut(pixOut),
  .outLineStart(outLineStart), .outLineEnd(outLineEnd), .cfgError(cfgError)
);

// File: tb/capture_window_bench.sv
`timescale 1ns/1ps
module capture_window_bench;

  localparam int CW = 15;
  localparam int DW = 12;

  typedef struct {
    logic v, ls, le, err;
    logic [DW-1:0] d;
    string req;
  } expItem_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic pixValid = 0, hSync = 0, vSync = 0, fieldOdd = 0, interlaced = 0;
  logic [DW-1:0] pixIn = '0;
  logic [CW-1:0] cfgHStart = 0, cfgHSize = 0, cfgVStartEven = 0, cfgVStartOdd = 0, cfgVSize = 0;
  logic outValid, outLineStart, outLineEnd, cfgError;
  logic [DW-1:0] pixOut;

  int total = 0, bad = 0;
  bit done = 0;
  string curReq = "R1";
  expItem_t q[$];

  // bench model state
  int mHs = 0, mHe = 0, mVs = 0, mVe = 0, hc = 0, lc = 0;
  bit mErr = 0, mArmed = 0, mLineOk = 0;
  logic [DW-1:0] seed = 12'h5a3;

  always #10 clk = ~clk;

  capture_window #(.CW(CW), .DW(DW)) u_capture_window (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .hSync(hSync), .vSync(vSync),
    .fieldOdd(fieldOdd), .pixIn(pixIn), .interlaced(interlaced),
    .cfgHStart(cfgHStart), .cfgHSize(cfgHSize), .cfgVStartEven(cfgVStartEven),
    .cfgVStartOdd(cfgVStartOdd), .cfgVSize(cfgVSize), .outValid(outValid),
    .pixOut(pixOut), .outLineStart(outLineStart), .outLineEnd(outLineEnd),
    .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: one input cycle plus its predicted outputs
  task automatic step(input bit pv, input bit hs, input bit vs, input bit fo);
    expItem_t e;
    bit pix, win;
    @(negedge clk);
    seed = seed * 12'd29 + 12'd7;
    pixValid = pv; hSync = hs; vSync = vs; fieldOdd = fo; pixIn = seed;
    pix = pv && !hs && !vs;
    win = pix && mArmed && mLineOk && !mErr && lc >= mVs && lc < mVe && hc >= mHs && hc < mHe;
    e.v = win; e.ls = win && hc == mHs; e.le = win && hc == mHe - 1;
    e.d = seed; e.req = curReq;
    if (vs) begin
      mHs = cfgHStart; mHe = cfgHStart + cfgHSize;
      mVs = (interlaced && fo) ? cfgVStartOdd : cfgVStartEven;
      mVe = mVs + cfgVSize;
      mErr = (cfgHSize % 16) != 0;
      lc = 0; hc = 0; mLineOk = 0; mArmed = 1;
    end else if (hs) begin
      hc = 0;
      if (mLineOk) lc++;
      mLineOk = 1;
    end else if (pv) hc++;
    e.err = mErr;
    q.push_back(e);
  endtask

  task automatic line(input int nPix, input int gap, input bit pvOnSync);
    step(pvOnSync, 1, 0, 0);
    for (int i = 0; i < nPix; i++) begin
      if (gap > 0 && i % gap == gap - 1) step(0, 0, 0, 0);
      step(1, 0, 0, 0);
    end
    step(0, 0, 0, 0);
  endtask

  task automatic frame(input bit fo, input int nLines, input int nPix, input int gap, input bit pvOnSync);
    step(pvOnSync, 0, 1, fo);
    step(0, 0, 0, 0);
    for (int l = 0; l < nLines; l++) line(nPix, gap, pvOnSync);
  endtask

  // monitor: compare one item per edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      check(outValid == e.v, e.req, "outValid", outValid, e.v);
      check(outLineStart == e.ls, e.req, "outLineStart R8", outLineStart, e.ls);
      check(outLineEnd == e.le, e.req, "outLineEnd R8", outLineEnd, e.le);
      check(cfgError == e.err, e.req, "cfgError R6", cfgError, e.err);
      if (e.v) check(pixOut == e.d, e.req, "pixOut R9", pixOut, e.d);
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!outValid && !outLineStart && !outLineEnd && !cfgError, "R1", "reset outputs",
          {outValid, outLineStart, outLineEnd, cfgError}, 0);
    cfgHStart = 3; cfgHSize = 16; cfgVStartEven = 2; cfgVStartOdd = 1; cfgVSize = 2;
    rstN = 1;
    // R10: nothing before first vSync
    curReq = "R10";
    line(24, 0, 1);
    // R2 R3 R5 R8: progressive, fieldOdd high has no effect
    curReq = "R5"; interlaced = 0;
    frame(1, 5, 24, 0, 0);
    curReq = "R2";
    frame(0, 5, 24, 0, 1);
    // R4: interlaced odd then even field
    curReq = "R4"; interlaced = 1;
    frame(1, 5, 24, 0, 0);
    frame(0, 5, 24, 0, 0);
    // R9: gaps in pixValid
    curReq = "R9";
    frame(1, 4, 24, 3, 0);
    // R3: window at line 0, wider line
    curReq = "R3"; interlaced = 0; cfgHStart = 0; cfgHSize = 32; cfgVStartEven = 0; cfgVSize = 3;
    frame(0, 4, 40, 0, 1);
    // R6: misaligned size, then recovery
    curReq = "R6"; cfgHSize = 20;
    frame(0, 3, 24, 0, 0);
    cfgHSize = 16;
    frame(0, 3, 24, 0, 0);
    // R7: mid-frame change takes effect only at next vSync
    curReq = "R7"; cfgHStart = 3; cfgVStartEven = 1; cfgVSize = 2;
    step(0, 0, 1, 0);
    line(24, 0, 0);
    cfgHStart = 6; cfgVStartEven = 0; cfgHSize = 20; cfgVSize = 4;
    line(24, 0, 0); line(24, 0, 0); line(24, 0, 0);
    cfgHSize = 16;
    frame(0, 3, 24, 0, 0);
    repeat (3) @(negedge clk);
    // R2: count of forwarded pixels in one known frame
    curReq = "R2"; cfgHStart = 2; cfgHSize = 16; cfgVStartEven = 1; cfgVSize = 1;
    step(0, 0, 1, 0);
    repeat (3) @(negedge clk);
    q.delete();
    seen = 0;
    fork
      begin
        repeat (2) line(30, 0, 0);
      end
      begin
        repeat (80) begin @(posedge clk); #3; if (outValid) seen++; end
      end
    join
    check(seen == 16, "R2", "pixels forwarded per frame", seen, 16);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule